// File: doc/BRIEF.md
# Recirculating Framed Serial Output Shifter

This block takes two processed result words from a codec core and sends them out on two framed serial lines. The first line carries an 8-bit linear sample and has its own bit clock. The second line carries a compressed code of 5 or 4 bits and also has its own bit clock. A frame strobe marks each period. When the strobe falls, the block takes the word that belongs to the coming period, but only if the load-valid flag is high. Otherwise it keeps the word it already holds.

The most significant bit goes out as soon as the strobe rises. Each later rising edge of a lane's bit clock, while the strobe stays high, moves that lane to the next lower bit. When a lane runs out of bits, it starts again at its MSB. It does not go idle and it does not shift in zeros. Both lanes run on a single system clock. The strobe and both bit clocks pass through one sampling register, and edges are found by comparing that sample with the value one cycle earlier.

The data words enter as a parallel interface qualified by the load-valid flag. There is no ready signal and no back-pressure. The block always accepts, and only at a strobe falling edge. A word offered at any other time is not taken. A falling edge with the flag low simply repeats the held pattern in the next period.

Top module: `frame_recirc_shifter`

## Requirements
- R1: While reset is asserted, and after reset until the first strobe rising edge, both serial outputs are 0.
- R2: On a strobe falling edge with `load_vld_i` high, the block captures the linear word, the compressed word and the rate code. On a falling edge with `load_vld_i` low, the words and rate held before are kept.
- R3: On a strobe rising edge, each output drives the MSB of its held word: bit 7 of the linear word; bit 4 of the compressed word in 5-bit rate, or bit 3 in 4-bit rate. Each lane's bit position restarts there, even in the middle of a pattern.
- R4: Each rising edge of `lin_bclk_i` while the strobe is high drives the next lower linear bit. After bit 0, the next edge drives bit 7 again.
- R5: Rate code 2'b00 selects 5-bit rate. Compressed bits go out as 4,3,2,1,0, and the fifth edge drives bit 4 again.
- R6: Rate codes 2'b01, 2'b10 and 2'b11 select 4-bit rate. Compressed bits go out as 3,2,1,0 and then repeat. Bit 4 of the compressed word is never driven.
- R7: While the strobe is low, both outputs hold their last value. Bit-clock edges in that time have no effect.
- R8: When a bit-clock rising edge reaches the block in the same cycle as a strobe rising edge, the lane drives its MSB.
- R9: A change of `rate_i` between loads has no effect until the next load.
- R10: Each serial output reflects a strobe or bit-clock edge on the second system-clock rising edge after the input changes.
- R11: Edges of one lane's bit clock never change the other lane's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous reset, active low |
| frame_i | input | 1 | frame strobe |
| lin_bclk_i | input | 1 | bit clock of the linear lane |
| cmp_bclk_i | input | 1 | bit clock of the compressed lane |
| rate_i | input | 2 | rate code: 00 selects 5-bit, any other value selects 4-bit |
| load_vld_i | input | 1 | qualifies the words at a strobe falling edge |
| lin_word_i | input | 8 | linear result word |
| cmp_word_i | input | 5 | compressed result word (4-bit codes use bits 3..0) |
| lin_sd_o | output | 1 | linear serial data |
| cmp_sd_o | output | 1 | compressed serial data |

## Verification
Every strobe or bit-clock change shows at the outputs on the second system-clock rising edge after it is driven: one edge for the sampling register, one for the output register. A load is taken on that same second edge. The driver changes one or more inputs on a falling clock edge and waits two rising edges. It then pushes the expected pair of output bits, which the monitor compares on the next falling edge, away from any update. Expected bits come from a small model in the bench that applies the wrap rules for 8, 5 and 4 bits, so long clock trains check the wrap-around in every rate.

// File: rtl/frame_recirc_pkg.sv
package frame_recirc_pkg;
  localparam int LIN_BITS = 8;
  localparam int CMP_BITS = 5;

  typedef enum logic [1:0] {
    RATE_FIVE   = 2'b00,
    RATE_FOUR_A = 2'b01,
    RATE_FOUR_B = 2'b10,
    RATE_FOUR_C = 2'b11
  } rate_e;
endpackage

// File: rtl/frame_edge_sense.sv
module frame_edge_sense #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] smp_q;
  logic [N-1:0] prv_q;

  generate
    for (genvar g = 0; g < N; g++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          smp_q[g] <= 1'b0;
          prv_q[g] <= 1'b0;
        end else begin
          smp_q[g] <= sig_i[g];
          prv_q[g] <= smp_q[g];
        end
      end
      assign lvl_o[g]  = smp_q[g];
      assign rise_o[g] = smp_q[g] & ~prv_q[g];
      assign fall_o[g] = ~smp_q[g] & prv_q[g];
    end
  endgenerate
endmodule

// File: rtl/frame_recirc_lane.sv
module frame_recirc_lane #(
  parameter int W  = 8,
  localparam int IW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [W-1:0]  word_i,
  input  logic [IW-1:0] len_i,
  input  logic          frm_hi_i,
  input  logic          frm_rise_i,
  input  logic          bclk_rise_i,
  output logic          sd_o,
  output logic [W-1:0]  word_o,
  output logic [IW-1:0] idx_o,
  output logic [IW-1:0] len_o
);
  logic [W-1:0]  word_q;
  logic [IW-1:0] len_q;
  logic [IW-1:0] idx_q;
  logic [IW-1:0] idx_nxt;
  logic [IW-1:0] pos;
  logic          step;
  logic          upd;
  logic          sd_q;

  assign step = bclk_rise_i & frm_hi_i;
  assign upd  = frm_rise_i | step;

  always_comb begin
    idx_nxt = idx_q;
    if (frm_rise_i)
      idx_nxt = '0;
    else if (step)
      idx_nxt = (idx_q == len_q - IW'(1)) ? '0 : idx_q + IW'(1);
  end

  assign pos = len_q - IW'(1) - idx_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      len_q  <= IW'(W);
      idx_q  <= '0;
      sd_q   <= 1'b0;
    end else begin
      if (load_i) begin
        word_q <= word_i;
        len_q  <= len_i;
      end
      if (upd) begin
        idx_q <= idx_nxt;
        sd_q  <= word_q[pos];
      end
    end
  end

  assign sd_o   = sd_q;
  assign word_o = word_q;
  assign idx_o  = idx_q;
  assign len_o  = len_q;
endmodule

// File: rtl/frame_recirc_shifter.sv
module frame_recirc_shifter
  import frame_recirc_pkg::*;
#(
  parameter int LIN_W = LIN_BITS,
  parameter int CMP_W = CMP_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_i,
  input  logic             lin_bclk_i,
  input  logic             cmp_bclk_i,
  input  logic [1:0]       rate_i,
  input  logic             load_vld_i,
  input  logic [LIN_W-1:0] lin_word_i,
  input  logic [CMP_W-1:0] cmp_word_i,
  output logic             lin_sd_o,
  output logic             cmp_sd_o
);
  localparam int LIW = $clog2(LIN_W + 1);
  localparam int CIW = $clog2(CMP_W + 1);

  logic [2:0] lvl, rise, fall;
  logic       frm_lvl, frm_rise, frm_fall, lin_rise, cmp_rise, ld;
  logic [LIN_W-1:0] lin_word;
  logic [CMP_W-1:0] cmp_word;
  logic [LIW-1:0]   lin_idx, lin_len;
  logic [CIW-1:0]   cmp_idx, cmp_len, cmp_len_in;

  frame_edge_sense #(.N(3)) u_sense (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_i  ({cmp_bclk_i, lin_bclk_i, frame_i}),
    .lvl_o  (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign frm_lvl  = lvl[0];
  assign frm_rise = rise[0];
  assign frm_fall = fall[0];
  assign lin_rise = rise[1];
  assign cmp_rise = rise[2];
  assign ld       = frm_fall & load_vld_i;

  assign cmp_len_in = (rate_e'(rate_i) == RATE_FIVE) ? CIW'(CMP_W) : CIW'(CMP_W - 1);

  frame_recirc_lane #(.W(LIN_W)) u_lin (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (ld),
    .word_i      (lin_word_i),
    .len_i       (LIW'(LIN_W)),
    .frm_hi_i    (frm_lvl),
    .frm_rise_i  (frm_rise),
    .bclk_rise_i (lin_rise),
    .sd_o        (lin_sd_o),
    .word_o      (lin_word),
    .idx_o       (lin_idx),
    .len_o       (lin_len)
  );

  frame_recirc_lane #(.W(CMP_W)) u_cmp (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (ld),
    .word_i      (cmp_word_i),
    .len_i       (cmp_len_in),
    .frm_hi_i    (frm_lvl),
    .frm_rise_i  (frm_rise),
    .bclk_rise_i (cmp_rise),
    .sd_o        (cmp_sd_o),
    .word_o      (cmp_word),
    .idx_o       (cmp_idx),
    .len_o       (cmp_len)
  );
endmodule

// File: rtl/frame_recirc_checker.sv
module frame_recirc_checker #(
  parameter int LIN_W = 8,
  parameter int CMP_W = 5,
  localparam int LIW = $clog2(LIN_W + 1),
  localparam int CIW = $clog2(CMP_W + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frm_lvl,
  input logic             frm_rise,
  input logic             frm_fall,
  input logic             lin_rise,
  input logic             cmp_rise,
  input logic             load_vld_i,
  input logic [LIN_W-1:0] lin_word_i,
  input logic [LIN_W-1:0] lin_word,
  input logic [LIW-1:0]   lin_idx,
  input logic [LIW-1:0]   lin_len,
  input logic [CIW-1:0]   cmp_idx,
  input logic [CIW-1:0]   cmp_len,
  input logic             lin_sd_o,
  input logic             cmp_sd_o
);
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_low_R1: assert (lin_sd_o == 1'b0 && cmp_sd_o == 1'b0);
    end
  end

  assert_load_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_fall && load_vld_i) |=> (lin_word == $past(lin_word_i)));

  assert_load_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_fall && !load_vld_i) |=> $stable(lin_word));

  assert_msb_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frm_rise |=> (lin_sd_o == lin_word[LIN_W-1] && lin_idx == '0 && cmp_idx == '0));

  assert_lin_idx_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lin_idx < lin_len);

  assert_cmp_idx_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_idx < cmp_len);

  assert_hold_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_lvl |=> ($stable(lin_sd_o) && $stable(cmp_sd_o)));

  assert_lane_apart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_lvl && !frm_rise && lin_rise && !cmp_rise) |=> $stable(cmp_sd_o));
endmodule

bind frame_recirc_shifter frame_recirc_checker #(.LIN_W(LIN_W), .CMP_W(CMP_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frm_lvl    (frm_lvl),
  .frm_rise   (frm_rise),
  .frm_fall   (frm_fall),
  .lin_rise   (lin_rise),
  .cmp_rise   (cmp_rise),
  .load_vld_i (load_vld_i),
  .lin_word_i (lin_word_i),
  .lin_word   (lin_word),
  .lin_idx    (lin_idx),
  .lin_len    (lin_len),
  .cmp_idx    (cmp_idx),
  .cmp_len    (cmp_len),
  .lin_sd_o   (lin_sd_o),
  .cmp_sd_o   (cmp_sd_o)
);

// File: tb/frame_recirc_shifter_tb_top.sv
`timescale 1ns/1ps
module frame_recirc_shifter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_i = 1'b0;
  logic       lin_bclk_i = 1'b1;
  logic       cmp_bclk_i = 1'b1;
  logic [1:0] rate_i = 2'b00;
  logic       load_vld_i = 1'b0;
  logic [7:0] lin_word_i = '0;
  logic [4:0] cmp_word_i = '0;
  logic       lin_sd_o, cmp_sd_o;

  always #2.5 clk = ~clk;

  frame_recirc_shifter dut_i (
    .clk(clk), .rst_n(rst_n), .frame_i(frame_i), .lin_bclk_i(lin_bclk_i),
    .cmp_bclk_i(cmp_bclk_i), .rate_i(rate_i), .load_vld_i(load_vld_i),
    .lin_word_i(lin_word_i), .cmp_word_i(cmp_word_i),
    .lin_sd_o(lin_sd_o), .cmp_sd_o(cmp_sd_o)
  );

  typedef struct {
    logic  lin;
    logic  cmp;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  int total = 0;
  int bad = 0;
  bit done = 0;

  // bench model, built from the requirements
  logic [7:0] m_lw = '0;
  logic [4:0] m_cw = '0;
  int m_clen = 5;
  int m_li = 0, m_ci = 0;
  logic m_frm = 0;
  logic e_lin = 0, e_cmp = 0;

  // monitor: compare on the falling edge after the push
  initial begin
    forever begin
      @(negedge clk);
      while (sb_q.size() > 0) begin
        exp_t it;
        it = sb_q.pop_front();
        total += 2;
        if (lin_sd_o !== it.lin) begin
          bad++;
          $display("FAIL %s lin_sd_o actual=%0b expected=%0b", it.tag, lin_sd_o, it.lin);
        end
        if (cmp_sd_o !== it.cmp) begin
          bad++;
          $display("FAIL %s cmp_sd_o actual=%0b expected=%0b", it.tag, cmp_sd_o, it.cmp);
        end
      end
    end
  end

  // R10: outputs are due on the second rising edge after a change
  task automatic expect_now(input string tag);
    exp_t it;
    repeat (2) @(posedge clk);
    it.lin = e_lin; it.cmp = e_cmp; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  task automatic frame_up(input logic lin_too, input logic cmp_too, input string tag);
    frame_i = 1'b1;
    if (lin_too) lin_bclk_i = 1'b1;
    if (cmp_too) cmp_bclk_i = 1'b1;
    m_frm = 1; m_li = 0; m_ci = 0;
    e_lin = m_lw[7];
    e_cmp = m_cw[m_clen-1];
    expect_now(tag);
  endtask

  task automatic frame_down(input logic vld, input logic [7:0] lw,
                            input logic [4:0] cw, input logic [1:0] rt, input string tag);
    load_vld_i = vld; lin_word_i = lw; cmp_word_i = cw; rate_i = rt;
    frame_i = 1'b0;
    m_frm = 0;
    if (vld) begin
      m_lw = lw; m_cw = cw; m_clen = (rt == 2'b00) ? 5 : 4;
    end
    expect_now(tag);
    load_vld_i = 1'b0;
  endtask

  task automatic lin_pulse(input string tag);
    lin_bclk_i = 1'b0;
    expect_now(tag);
    lin_bclk_i = 1'b1;
    if (m_frm) begin
      m_li = (m_li == 7) ? 0 : m_li + 1;
      e_lin = m_lw[7 - m_li];
    end
    expect_now(tag);
  endtask

  task automatic cmp_pulse(input string tag);
    cmp_bclk_i = 1'b0;
    expect_now(tag);
    cmp_bclk_i = 1'b1;
    if (m_frm) begin
      m_ci = (m_ci == m_clen - 1) ? 0 : m_ci + 1;
      e_cmp = m_cw[m_clen - 1 - m_ci];
    end
    expect_now(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (lin_sd_o !== 1'b0 || cmp_sd_o !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset actual=%0b%0b expected=00", lin_sd_o, cmp_sd_o);
    end
    rst_n = 1'b1;
    @(negedge clk);
    expect_now("R1 after reset");

    // R2 and R5: load in 5-bit rate
    frame_up(0, 0, "R1 first rise, empty words");
    frame_down(1, 8'hA5, 5'b10110, 2'b00, "R7 hold at load");
    frame_up(0, 0, "R3 msb on rise");
    for (int i = 0; i < 9; i++) lin_pulse("R4 linear step and wrap");
    for (int i = 0; i < 7; i++) cmp_pulse("R5 five-bit step and wrap");

    // R2: load refused, R7: edges while strobe low ignored
    frame_down(0, 8'h3C, 5'b01001, 2'b01, "R2 no load");
    lin_pulse("R7 linear edge with strobe low");
    cmp_pulse("R7 compressed edge with strobe low");
    frame_up(0, 0, "R2 held word and rate after refused load");
    lin_pulse("R3 linear restart");
    cmp_pulse("R5 held five-bit rate");
    cmp_pulse("R5 held five-bit rate");

    // R6: 4-bit rate, bit 4 set but never driven
    frame_down(1, 8'h3C, 5'b10110, 2'b10, "R6 load four-bit");
    frame_up(0, 0, "R6 msb is bit 3");
    rate_i = 2'b00;
    for (int i = 0; i < 6; i++) cmp_pulse("R6 R9 four-bit wrap, rate change ignored");
    for (int i = 0; i < 3; i++) lin_pulse("R11 linear edges with compressed lane idle");

    // R3: restart mid-pattern; R8: simultaneous edges
    frame_down(1, 8'h81, 5'b11001, 2'b11, "R2 reload");
    lin_bclk_i = 1'b0; cmp_bclk_i = 1'b0;
    expect_now("R7 clocks low with strobe low");
    frame_up(1, 1, "R8 strobe and bit clock together give msb");
    lin_pulse("R8 next linear bit");
    cmp_pulse("R6 four-bit rate code 11");
    frame_down(0, 8'h00, 5'b00000, 2'b00, "R7 hold");
    frame_up(0, 0, "R3 restart from msb");
    for (int i = 0; i < 8; i++) lin_pulse("R4 full linear cycle");

    repeat (3) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule